// File: doc/BRIEF.md
# Shared Status and Command Byte with Split Bit Ownership

This block keeps one 8-bit status/command byte that two agents update: a processor, through byte or single-bit writes, and a serial transfer engine, through per-bit set and clear pulses. Each bit has its own rule for which agent may set it, which may clear it, and which agent wins when both act in the same cycle. The bits implement a transmit-ready handshake, a receive-enable handshake, a request-to-send control with an active-low pin, an interrupt flag and an overrun flag. Three further bits are plain processor-owned storage.

Handshake pattern: the processor raises a flag, and the serial engine drops it when it has consumed the buffer or finished a frame. The interrupt flag is the reverse: the engine raises it and the processor acknowledges it. Every update becomes visible on `sts_o` on the clock edge after the request. The interrupt output and the request-to-send pin follow the stored bits without further delay.

Top module: `hs_status_reg`

## Requirements
- R1: While `rst_n` is low, all eight bits of `sts_o` read 0, `irq_o` reads 0 and `rts_n_o` reads 1.
- R2: A processor byte write (`cpu_byte_we`=1) loads all eight bits from `cpu_byte_d` on the next edge, subject only to the serial-priority rules of R7 and R8. If a bit write is requested in the same cycle, the bit write is ignored.
- R3: A processor bit write (`cpu_bit_we`=1, `cpu_byte_we`=0) loads `cpu_bit_d` into the bit numbered `cpu_bit_idx` and leaves the other seven bits unchanged. Bit numbering: 7 transmit-full, 6 receive-empty, 5 request-to-send, 4 interrupt, 3 overrun, 2..0 general-purpose.
- R4: A serial clear pulse on bit 7 (transmit-full) clears it, and a serial set pulse on bit 7 has no effect. A processor write to bit 7 in the same cycle wins over the serial clear.
- R5: Bit 6 (receive-empty) follows the same rules as R4: the serial unit can only clear it, and a processor write in the same cycle wins.
- R6: Bit 5 (request-to-send) takes serial set and clear pulses only while `ser_auto`=1, with set winning over clear. While `ser_auto`=0 these pulses are ignored. A processor write in the same cycle wins.
- R7: Bit 4 (interrupt) is set by a serial set pulse, and a serial clear pulse on it is ignored. A serial set overrides a processor write in the same cycle. `irq_o` equals bit 4.
- R8: Bit 3 (overrun) accepts serial set and clear pulses, with set winning over clear. Any serial pulse on bit 3 overrides a processor write in the same cycle.
- R9: Serial set and clear pulses on bits 2..0 have no effect. Those bits change only through processor writes.
- R10: With `loop_mode`=0, `rts_n_o` is the inverse of bit 5. With `loop_mode`=1, `rts_n_o` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_byte_we | input | 1 | Processor byte write strobe |
| cpu_byte_d | input | 8 | Processor byte write data |
| cpu_bit_we | input | 1 | Processor single-bit write strobe |
| cpu_bit_idx | input | 3 | Index of the bit to write |
| cpu_bit_d | input | 1 | Value for the single-bit write |
| ser_set | input | 8 | Serial-engine set pulses, one per bit |
| ser_clr | input | 8 | Serial-engine clear pulses, one per bit |
| ser_auto | input | 1 | Allows the serial engine to drive the request-to-send bit |
| loop_mode | input | 1 | Loop configuration; forces the pin inactive |
| sts_o | output | 8 | Current register value |
| irq_o | output | 1 | Interrupt request, equal to bit 4 |
| rts_n_o | output | 1 | Active-low request-to-send pin |

## Verification
Byte writes with mixed data patterns show that every bit is loaded in the same cycle. Single-bit writes with the other bits held at known values show that a write cannot spill into a neighbouring bit. Both-agents-in-one-cycle patterns are driven on every bit, and they separate the processor-wins bits (7, 6, 5) from the serial-wins bits (4, 3). All-ones serial pulse vectors are sent against the processor-owned bits, and against bit 5 with auto mode off, to show that those pulses are ignored. Toggling loop mode with bit 5 held at both values shows that the pin follows the bit only outside loop mode.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int STS_W = 8;
  localparam int IDX_W = $clog2(STS_W);

  // Bit positions (decoded by the serial engine and the interrupt logic)
  localparam int B_TXF  = 7;
  localparam int B_RXE  = 6;
  localparam int B_RTS  = 5;
  localparam int B_IRQ  = 4;
  localparam int B_OVR  = 3;

  // Per-bit ownership: which serial pulses are honoured, and who wins a collision
  localparam logic [STS_W-1:0] SER_SET_OK  = 8'b0011_1000;
  localparam logic [STS_W-1:0] SER_CLR_OK  = 8'b1110_1000;
  localparam logic [STS_W-1:0] SER_WINS    = 8'b0001_1000;
  localparam logic [STS_W-1:0] AUTO_GATED  = 8'b0010_0000;
  localparam logic [STS_W-1:0] RST_VALUE   = 8'b0000_0000;

  typedef struct packed {
    logic [STS_W-1:0] mask;
    logic [STS_W-1:0] data;
  } cpu_wr_t;

  // Next value of one bit given both agents' requests
  function automatic logic cell_next(input logic cur, input logic cpu_we,
                                     input logic cpu_d, input logic s_set,
                                     input logic s_clr, input logic ser_wins);
    logic ser_act;
    ser_act = s_set | s_clr;
    if (cpu_we && !(ser_wins && ser_act)) return cpu_d;
    if (s_set) return 1'b1;
    if (s_clr) return 1'b0;
    return cur;
  endfunction

  // Merge the byte and bit write ports into one mask/data pair
  function automatic cpu_wr_t cpu_decode(input logic byte_we,
                                         input logic [STS_W-1:0] byte_d,
                                         input logic bit_we,
                                         input logic [IDX_W-1:0] idx,
                                         input logic bit_d);
    cpu_wr_t r;
    r.mask = '0;
    r.data = '0;
    if (byte_we) begin
      r.mask = '1;
      r.data = byte_d;
    end else if (bit_we) begin
      r.mask[idx] = 1'b1;
      r.data = {STS_W{bit_d}};
    end
    return r;
  endfunction
endpackage

// File: rtl/hs_cpu_port.sv
module hs_cpu_port
  import hs_pkg::*;
(
  input  logic             byte_we,
  input  logic [STS_W-1:0] byte_d,
  input  logic             bit_we,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_d,
  output logic [STS_W-1:0] we_mask,
  output logic [STS_W-1:0] wdata
);
  cpu_wr_t dec;

  always_comb begin
    dec     = cpu_decode(byte_we, byte_d, bit_we, bit_idx, bit_d);
    we_mask = dec.mask;
    wdata   = dec.data;
  end

  // R3
  always_comb begin
    if (!byte_we) bit_mask_onehot_chk: assert ($onehot0(we_mask));
  end
endmodule

// File: rtl/hs_bit_cell.sv
module hs_bit_cell #(
  parameter bit CAN_SET  = 1'b0,
  parameter bit CAN_CLR  = 1'b0,
  parameter bit SER_WIN  = 1'b0,
  parameter bit RST_VAL  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_we,
  input  logic cpu_d,
  input  logic ser_set,
  input  logic ser_clr,
  output logic q
);
  logic s_set, s_clr, q_nxt;

  assign s_set = CAN_SET ? ser_set : 1'b0;
  assign s_clr = CAN_CLR ? ser_clr : 1'b0;
  assign q_nxt = hs_pkg::cell_next(q, cpu_we, cpu_d, s_set, s_clr, SER_WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_we && !s_set && !s_clr) |=> $stable(q));

  generate
    if (SER_WIN) begin : g_ser_win
      // R8
      ser_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_set |=> q);
    end else begin : g_cpu_win
      // R4
      cpu_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |=> (q == $past(cpu_d)));
    end
  endgenerate
endmodule

// File: rtl/hs_status_reg.sv
module hs_status_reg
  import hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_byte_we,
  input  logic [STS_W-1:0] cpu_byte_d,
  input  logic             cpu_bit_we,
  input  logic [IDX_W-1:0] cpu_bit_idx,
  input  logic             cpu_bit_d,
  input  logic [STS_W-1:0] ser_set,
  input  logic [STS_W-1:0] ser_clr,
  input  logic             ser_auto,
  input  logic             loop_mode,
  output logic [STS_W-1:0] sts_o,
  output logic             irq_o,
  output logic             rts_n_o
);
  logic [STS_W-1:0] cpu_we_mask, cpu_wdata;
  logic [STS_W-1:0] ser_gate, ser_set_g, ser_clr_g;
  logic [STS_W-1:0] sts_q;

  hs_cpu_port u_cpu (
    .byte_we (cpu_byte_we),
    .byte_d  (cpu_byte_d),
    .bit_we  (cpu_bit_we),
    .bit_idx (cpu_bit_idx),
    .bit_d   (cpu_bit_d),
    .we_mask (cpu_we_mask),
    .wdata   (cpu_wdata)
  );

  // Auto-gated bits only see serial pulses in auto mode
  assign ser_gate  = ser_auto ? '1 : ~AUTO_GATED;
  assign ser_set_g = ser_set & ser_gate;
  assign ser_clr_g = ser_clr & ser_gate;

  generate
    for (genvar i = 0; i < STS_W; i++) begin : g_bit
      hs_bit_cell #(
        .CAN_SET (SER_SET_OK[i]),
        .CAN_CLR (SER_CLR_OK[i]),
        .SER_WIN (SER_WINS[i]),
        .RST_VAL (RST_VALUE[i])
      ) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_we  (cpu_we_mask[i]),
        .cpu_d   (cpu_wdata[i]),
        .ser_set (ser_set_g[i]),
        .ser_clr (ser_clr_g[i]),
        .q       (sts_q[i])
      );
    end
  endgenerate

  assign sts_o   = sts_q;
  assign irq_o   = sts_q[B_IRQ];
  assign rts_n_o = loop_mode ? 1'b1 : ~sts_q[B_RTS];

  // R10
  rts_loop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_mode |-> rts_n_o);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ser_set[B_IRQ] || cpu_we_mask[B_IRQ]));

  // R7
  irq_not_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_set[B_IRQ] |=> irq_o);

  // R6
  rts_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_auto && !cpu_we_mask[B_RTS]) |=> $stable(sts_o[B_RTS]));
endmodule

// File: tb/sim_hs_status_reg.sv
`timescale 1ns/100ps
module sim_hs_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_byte_we = 1'b0;
  logic [7:0] cpu_byte_d = '0;
  logic       cpu_bit_we = 1'b0;
  logic [2:0] cpu_bit_idx = '0;
  logic       cpu_bit_d = 1'b0;
  logic [7:0] ser_set = '0;
  logic [7:0] ser_clr = '0;
  logic       ser_auto = 1'b0;
  logic       loop_mode = 1'b0;
  logic [7:0] sts_o;
  logic       irq_o, rts_n_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    logic [7:0] q;
    logic       irq;
    logic       rtsn;
    string      tag;
  } exp_t;
  exp_t sb[$];
  logic [7:0] mdl = '0;

  always #2 clk = ~clk;

  hs_status_reg u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_byte_we(cpu_byte_we), .cpu_byte_d(cpu_byte_d),
    .cpu_bit_we(cpu_bit_we), .cpu_bit_idx(cpu_bit_idx), .cpu_bit_d(cpu_bit_d),
    .ser_set(ser_set), .ser_clr(ser_clr), .ser_auto(ser_auto),
    .loop_mode(loop_mode),
    .sts_o(sts_o), .irq_o(irq_o), .rts_n_o(rts_n_o)
  );

  // Reference: each bit's rule written out by name
  function automatic logic [7:0] ref_next(input logic [7:0] cur,
      input logic bwe, input logic [7:0] bd, input logic biwe,
      input logic [2:0] bidx, input logic bval,
      input logic [7:0] st, input logic [7:0] cl, input logic aut);
    logic [7:0] wm, wd, n;
    wm = '0; wd = '0; n = cur;
    if (bwe) begin wm = 8'hFF; wd = bd; end
    else if (biwe) begin wm[bidx] = 1'b1; wd[bidx] = bval; end
    // transmit-full, receive-empty: serial clears, cpu wins
    for (int b = 6; b <= 7; b++) begin
      if (wm[b]) n[b] = wd[b];
      else if (cl[b]) n[b] = 1'b0;
    end
    // request-to-send
    if (wm[5]) n[5] = wd[5];
    else if (aut && st[5]) n[5] = 1'b1;
    else if (aut && cl[5]) n[5] = 1'b0;
    // interrupt: serial set beats cpu
    if (st[4]) n[4] = 1'b1;
    else if (wm[4]) n[4] = wd[4];
    // overrun: serial set/clear beat cpu
    if (st[3]) n[3] = 1'b1;
    else if (cl[3]) n[3] = 1'b0;
    else if (wm[3]) n[3] = wd[3];
    // general-purpose bits
    for (int b = 0; b <= 2; b++) if (wm[b]) n[b] = wd[b];
    return n;
  endfunction

  task automatic chk(input string tag, input logic [7:0] aq, input logic ai,
                     input logic ar, input logic [7:0] eq, input logic ei,
                     input logic er);
    n_cmp++;
    if (aq !== eq || ai !== ei || ar !== er) begin
      n_bad++;
      $display("FAIL %s: got sts=%02h irq=%b rts_n=%b, want sts=%02h irq=%b rts_n=%b",
               tag, aq, ai, ar, eq, ei, er);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic bwe, input logic [7:0] bd, input logic biwe,
                      input logic [2:0] bidx, input logic bval,
                      input logic [7:0] st, input logic [7:0] cl,
                      input logic aut, input logic lp, input string tag);
    exp_t e;
    @(negedge clk); #1;
    cpu_byte_we = bwe; cpu_byte_d = bd; cpu_bit_we = biwe;
    cpu_bit_idx = bidx; cpu_bit_d = bval; ser_set = st; ser_clr = cl;
    ser_auto = aut; loop_mode = lp;
    mdl = ref_next(mdl, bwe, bd, biwe, bidx, bval, st, cl, aut);
    e.q = mdl; e.irq = mdl[4]; e.rtsn = lp ? 1'b1 : !mdl[5]; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, sts_o, irq_o, rts_n_o, e.q, e.irq, e.rtsn);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang, want completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", sts_o, irq_o, rts_n_o, 8'h00, 1'b0, 1'b1);
    #1 rst_n = 1'b1;
    //    bwe bd     biwe idx v  set    clr    aut lp
    step(1, 8'hA5, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R2 byte A5");
    step(1, 8'h5A, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R2 byte 5A");
    step(1, 8'h00, 1, 2, 1, 8'h00, 8'h00, 0, 0, "R2 byte beats bit");
    step(0, 8'h00, 1, 2, 1, 8'h00, 8'h00, 0, 0, "R3 bit2 set");
    step(0, 8'h00, 1, 0, 1, 8'h00, 8'h00, 0, 0, "R3 bit0 set");
    step(0, 8'h00, 1, 2, 0, 8'h00, 8'h00, 0, 0, "R3 bit2 clr");
    step(0, 8'h00, 1, 7, 1, 8'h00, 8'h00, 0, 0, "R4 cpu sets txf");
    step(0, 8'h00, 0, 0, 0, 8'h80, 8'h00, 1, 0, "R4 ser set txf ignored");
    step(0, 8'h00, 0, 0, 0, 8'h00, 8'h80, 0, 0, "R4 ser clr txf");
    step(0, 8'h00, 1, 7, 1, 8'h00, 8'h80, 0, 0, "R4 cpu beats ser clr");
    step(0, 8'h00, 1, 6, 1, 8'h00, 8'h00, 0, 0, "R5 cpu sets rxe");
    step(0, 8'h00, 0, 0, 0, 8'h00, 8'h40, 0, 0, "R5 ser clr rxe");
    step(0, 8'h00, 1, 6, 1, 8'h00, 8'h40, 0, 0, "R5 cpu beats ser clr");
    step(0, 8'h00, 0, 0, 0, 8'h20, 8'h00, 0, 0, "R6 ser set rts manual ignored");
    step(0, 8'h00, 0, 0, 0, 8'h20, 8'h00, 1, 0, "R6 ser set rts auto / R10 pin");
    step(0, 8'h00, 0, 0, 0, 8'h00, 8'h20, 0, 0, "R6 ser clr rts manual ignored");
    step(0, 8'h00, 0, 0, 0, 8'h00, 8'h00, 0, 1, "R10 loop holds pin high");
    step(0, 8'h00, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R10 pin follows bit");
    step(0, 8'h00, 0, 0, 0, 8'h20, 8'h20, 1, 0, "R6 set beats clr");
    step(0, 8'h00, 1, 5, 0, 8'h20, 8'h00, 1, 0, "R6 cpu beats ser set");
    step(0, 8'h00, 0, 0, 0, 8'h00, 8'h00, 0, 1, "R10 loop, rts low");
    step(0, 8'h00, 0, 0, 0, 8'h10, 8'h00, 0, 0, "R7 ser set irq");
    step(0, 8'h00, 0, 0, 0, 8'h00, 8'h10, 0, 0, "R7 ser clr irq ignored");
    step(0, 8'h00, 1, 4, 0, 8'h00, 8'h00, 0, 0, "R7 cpu clears irq");
    step(0, 8'h00, 1, 4, 0, 8'h10, 8'h00, 0, 0, "R7 ser set beats cpu clr");
    step(1, 8'h00, 0, 0, 0, 8'h10, 8'h00, 0, 0, "R7 ser set beats byte clr");
    step(0, 8'h00, 0, 0, 0, 8'h08, 8'h00, 0, 0, "R8 ser set ovr");
    step(0, 8'h00, 0, 0, 0, 8'h00, 8'h08, 0, 0, "R8 ser clr ovr");
    step(0, 8'h00, 0, 0, 0, 8'h08, 8'h08, 0, 0, "R8 set beats clr");
    step(0, 8'h00, 1, 3, 1, 8'h00, 8'h08, 0, 0, "R8 ser clr beats cpu set");
    step(0, 8'h00, 1, 3, 1, 8'h00, 8'h00, 0, 0, "R8 cpu sets ovr");
    step(1, 8'h02, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R2 byte 02");
    step(0, 8'h00, 0, 0, 0, 8'h05, 8'h02, 1, 0, "R9 gp bits ignore serial");
    step(0, 8'h00, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R9 idle");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: got %0d pending, want 0", sb.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule